// File: doc/BRIEF.md
# Periodic Transmit Scheduler

This block decides the cycles in which a word serializer downstream starts a new word. It runs on a 1 MHz clock. It watches a transmit-enable pin, an 8-bit repeat code, a line-rate select and two reset sources. When a word should begin, it issues a single-cycle start pulse. A rising edge on the enable sends a word at once. While the enable stays high, words repeat at the interval the code selects: the code times 10 ms for non-zero codes, or one full word time at the selected line rate for code zero. After any reset, every start is held back for a fixed lockout window of 500 ms.

The serializer and the scheduler share a plain start/busy handshake, which acts as the back-pressure. A start is only issued in a cycle where the serializer's busy input is low. A request that comes up while busy is high is kept and served in the first cycle busy is low again. In zero-code mode the serializer's done pulse ends the wait at once, so words can run back to back. Word formatting and line encoding belong to the serializer and are not handled here.

Top module: `tx_sched`

## Requirements
- R1: Either reset input (`ext_rst_i` or `pwr_rst_i`, active high, synchronous) holds `start_o` low while it is asserted. Releasing either one restarts the lockout window.
- R2: No start is issued during the first LOCK_CYC cycles after reset is released (default 500,000, i.e. 500 ms). With reset released in cycle c0, the earliest start is in cycle c0+LOCK_CYC.
- R3: A 0-to-1 change of `tx_en_i`, outside lockout and with `ser_busy_i` low, raises `start_o` in the same cycle.
- R4: No start is issued while `tx_en_i` is low. A pending rising edge is discarded if the enable falls before that edge is served.
- R5: For a non-zero `ival_code_i` N, while the enable stays high, the next start comes N×TICK_CYC cycles after the previous start (default TICK_CYC is 10,000, so the interval is N×10 ms).
- R6: For `ival_code_i` equal to 0, the start-to-start spacing is WORD_BITS×bit time. The bit time is BIT_CYC_SLOW cycles when `fast_i`=0 and BIT_CYC_FAST cycles when `fast_i`=1 (defaults give 36×80 = 2880 and 36×10 = 360 cycles).
- R7: For `ival_code_i` equal to 0, a `ser_done_i` pulse after a word has started triggers the next start in the same cycle.
- R8: `start_o` is never high while `ser_busy_i` is high. A periodic request that falls due while busy is served in the first cycle with busy low.
- R9: A rising edge of the enable that arrives during lockout is kept, and it is served in the first cycle after lockout ends.
- R10: Every start is a single-cycle pulse. No two consecutive cycles both carry a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1 MHz scheduler clock |
| ext_rst_i | input | 1 | External master reset, active high |
| pwr_rst_i | input | 1 | Power-on reset, active high |
| tx_en_i | input | 1 | Transmit enable; rising edge sends, high level repeats |
| ival_code_i | input | 8 | Repeat interval code in 10 ms units; 0 means back-to-back |
| fast_i | input | 1 | Line rate select: 0 slow, 1 fast |
| ser_busy_i | input | 1 | Serializer is shifting a word |
| ser_done_i | input | 1 | Serializer finished a word (one-cycle pulse) |
| start_o | output | 1 | One-cycle word start request |

## Verification
The assertions assume the following about the inputs. All inputs are synchronous to the clock. The serializer raises busy in response to a start and does not pulse done in the cycle right after a start. The interval code and rate select are held steady while the enable is high. The stimulus keeps to these rules: every input changes just after a rising clock edge, and busy and done are only driven as short pulses. In the random loop, the enable is dropped before a new code or rate is applied. The loop picks random codes 0 to 3, random rates and random idle gaps, then measures the start-to-start spacing. The directed cases cover reset, lockout, busy deferral, done-driven restart and discarded edges.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;

  typedef enum logic {
    TXS_SLOW = 1'b0,
    TXS_FAST = 1'b1
  } txs_rate_e;

  // cycles taken by one word at a given bit time
  function automatic int txs_word_cycles(input int bits, input int bit_cyc);
    return bits * bit_cyc;
  endfunction

endpackage

// File: rtl/tx_sched_lockout.sv
module tx_sched_lockout #(
  parameter int LOCK_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic locked_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] remain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      remain_q <= LW'(LOCK_CYC);
    end else if (remain_q != '0) begin
      remain_q <= remain_q - LW'(1);
    end
  end

  assign locked_o = (remain_q != '0);
endmodule

// File: rtl/tx_sched_interval.sv
module tx_sched_interval #(
  parameter int TICK_CYC = 10000,
  parameter int CODE_W   = 8,
  parameter int GAP_SLOW = 2880,
  parameter int GAP_FAST = 360
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fast_i,
  output logic              expire_o
);
  localparam int PW      = $clog2(TICK_CYC);
  localparam int GAP_MAX = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
  localparam int GW      = $clog2(GAP_MAX + 1);

  logic [PW-1:0]     pre_q;
  logic [CODE_W-1:0] ticks_q;
  logic [GW-1:0]     gap_q;
  logic              idle_q;

  logic              pre_wrap;
  logic              zero_code;
  logic [CODE_W-1:0] code_m1;
  logic [GW-1:0]     gap_last;
  logic              hit_code;
  logic              hit_gap;

  assign pre_wrap  = (pre_q == PW'(TICK_CYC - 1));
  assign zero_code = (code_i == '0);
  assign code_m1   = code_i - CODE_W'(1);
  assign gap_last  = fast_i ? GW'(GAP_FAST - 1) : GW'(GAP_SLOW - 1);
  assign hit_code  = !zero_code && pre_wrap && (ticks_q == code_m1);
  assign hit_gap   = zero_code && (gap_q == gap_last);
  assign expire_o  = !idle_q && (hit_code || hit_gap);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pre_q   <= '0;
      ticks_q <= '0;
      gap_q   <= '0;
      idle_q  <= 1'b1;
    end else if (restart_i) begin
      pre_q   <= '0;
      ticks_q <= '0;
      gap_q   <= '0;
      idle_q  <= 1'b0;
    end else if (!idle_q) begin
      pre_q   <= pre_wrap ? '0 : pre_q + PW'(1);
      ticks_q <= pre_wrap ? ticks_q + CODE_W'(1) : ticks_q;
      gap_q   <= gap_q + GW'(1);
      idle_q  <= expire_o;
    end
  end
endmodule

// File: rtl/tx_sched.sv
module tx_sched
  import tx_sched_pkg::*;
#(
  parameter int TICK_CYC     = 10000,
  parameter int LOCK_CYC     = 500000,
  parameter int CODE_W       = 8,
  parameter int WORD_BITS    = 36,
  parameter int BIT_CYC_SLOW = 80,
  parameter int BIT_CYC_FAST = 10
) (
  input  logic              clk_i,
  input  logic              ext_rst_i,
  input  logic              pwr_rst_i,
  input  logic              tx_en_i,
  input  logic [CODE_W-1:0] ival_code_i,
  input  logic              fast_i,
  input  logic              ser_busy_i,
  input  logic              ser_done_i,
  output logic              start_o
);
  localparam int GAP_SLOW = txs_word_cycles(WORD_BITS, BIT_CYC_SLOW);
  localparam int GAP_FAST = txs_word_cycles(WORD_BITS, BIT_CYC_FAST);

  logic      rst;
  logic      locked;
  logic      expire;
  txs_rate_e rate;

  logic en_q, pend_q, armed_q, due_q;
  logic rise, zero_code, period_hit, start;

  assign rst       = ext_rst_i | pwr_rst_i;
  assign rate      = txs_rate_e'(fast_i);
  assign zero_code = (ival_code_i == '0);

  tx_sched_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i   (clk_i),
    .rst_i   (rst),
    .locked_o(locked)
  );

  tx_sched_interval #(
    .TICK_CYC(TICK_CYC),
    .CODE_W  (CODE_W),
    .GAP_SLOW(GAP_SLOW),
    .GAP_FAST(GAP_FAST)
  ) u_ival (
    .clk_i    (clk_i),
    .rst_i    (rst),
    .restart_i(start),
    .code_i   (ival_code_i),
    .fast_i   (rate == TXS_FAST),
    .expire_o (expire)
  );

  // request sources: a fresh or held edge, or a periodic deadline
  assign rise       = tx_en_i & ~en_q;
  assign period_hit = armed_q & (expire | (zero_code & ser_done_i));
  assign start      = ~rst & tx_en_i & ~locked & ~ser_busy_i &
                      (pend_q | rise | due_q | period_hit);
  assign start_o    = start;

  always_ff @(posedge clk_i) begin
    if (rst) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      due_q   <= 1'b0;
    end else begin
      en_q    <= tx_en_i;
      pend_q  <= tx_en_i & (pend_q | rise) & ~start;
      armed_q <= tx_en_i & (armed_q | start);
      due_q   <= tx_en_i & (due_q | period_hit) & ~start;
    end
  end
endmodule

// File: rtl/tx_sched_chk.sv
module tx_sched_chk #(
  parameter int LOCK_CYC = 500000
) (
  input logic clk_i,
  input logic ext_rst_i,
  input logic pwr_rst_i,
  input logic tx_en_i,
  input logic ser_busy_i,
  input logic start_o
);
  logic        rst;
  int unsigned since_q;

  assign rst = ext_rst_i | pwr_rst_i;

  always_ff @(posedge clk_i) begin
    if (rst) since_q <= 0;
    else if (since_q < LOCK_CYC) since_q <= since_q + 1;
  end

  always @(posedge clk_i) begin
    if (rst) p_quiet_in_reset_r1: assert (!start_o);
  end

  p_lockout_hold_r2: assert property (@(posedge clk_i) disable iff (rst)
    start_o |-> (since_q == LOCK_CYC));

  p_edge_now_r3: assert property (@(posedge clk_i) disable iff (rst)
    ($rose(tx_en_i) && !ser_busy_i && since_q == LOCK_CYC) |-> start_o);

  p_enable_gate_r4: assert property (@(posedge clk_i) disable iff (rst)
    start_o |-> tx_en_i);

  p_busy_gate_r8: assert property (@(posedge clk_i) disable iff (rst)
    start_o |-> !ser_busy_i);
endmodule

bind tx_sched tx_sched_chk #(.LOCK_CYC(LOCK_CYC)) i_chk (
  .clk_i     (clk_i),
  .ext_rst_i (ext_rst_i),
  .pwr_rst_i (pwr_rst_i),
  .tx_en_i   (tx_en_i),
  .ser_busy_i(ser_busy_i),
  .start_o   (start_o)
);

// File: tb/test_tx_sched.sv
module test_tx_sched;
  localparam int TICK = 20, LOCK = 300, WB = 36, BLO = 8, BHI = 2;
  localparam int GAP_LO = WB * BLO, GAP_HI = WB * BHI;

  logic clk = 1'b0, ext_rst = 1'b1, pwr_rst = 1'b0, en = 1'b0;
  logic fast = 1'b0, busy = 1'b0, done = 1'b0, start;
  logic [7:0] code = 8'd0;
  int cyc = 0, n_chk = 0, n_bad = 0, n_start = 0, last_start = -10;
  bit finished = 0;

  tx_sched #(.TICK_CYC(TICK), .LOCK_CYC(LOCK), .WORD_BITS(WB),
             .BIT_CYC_SLOW(BLO), .BIT_CYC_FAST(BHI)) i_tx_sched (
    .clk_i(clk), .ext_rst_i(ext_rst), .pwr_rst_i(pwr_rst), .tx_en_i(en),
    .ival_code_i(code), .fast_i(fast), .ser_busy_i(busy),
    .ser_done_i(done), .start_o(start));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(input int c, input bit f);
    return (c == 0) ? (f ? GAP_HI : GAP_LO) : c * TICK;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // global monitor for R4, R8, R10
  always @(negedge clk) begin
    if (start && !ext_rst && !pwr_rst) begin
      chk(last_start != cyc - 1, "R10", cyc, last_start + 2);
      chk(!busy, "R8", int'(busy), 0);
      chk(en, "R4", int'(en), 1);
      n_start++;
      last_start = cyc;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_start(output int at);
    at = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (start) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0, a, b, e, s0;
    void'($urandom(32'd1234));
    // R1: quiet during reset, even with enable high
    step(3);
    en = 1'b1;
    code = 8'd2;
    step(2);
    @(negedge clk);
    chk(start == 1'b0, "R1", int'(start), 0);
    step(1);
    ext_rst = 1'b0;
    c0 = cyc;
    // R2: first start exactly when lockout expires
    wait_start(a);
    chk(a == c0 + LOCK, "R2", a, c0 + LOCK);
    // R5: code 2 repeats every 2*TICK
    wait_start(b);
    chk(b - a == 2 * TICK, "R5", b - a, 2 * TICK);
    wait_start(a);
    chk(a - b == 2 * TICK, "R5", a - b, 2 * TICK);
    // R4: enable low, nothing sent
    step(1);
    en = 1'b0;
    s0 = n_start;
    step(200);
    chk(n_start == s0, "R4", n_start - s0, 0);
    // R1/R9: power reset restarts lockout; edge inside lockout is kept
    pwr_rst = 1'b1;
    step(3);
    pwr_rst = 1'b0;
    c0 = cyc;
    step(50);
    en = 1'b1;
    wait_start(a);
    chk(a == c0 + LOCK, "R9", a, c0 + LOCK);
    step(1);
    code = 8'd1;
    // R8: deadline while busy is deferred to the first idle cycle
    wait_start(a);
    step(1);
    busy = 1'b1;
    step(29);
    busy = 1'b0;
    e = cyc;
    wait_start(b);
    chk(b == e, "R8", b, e);
    // R4: edge during busy dropped when enable falls before service
    step(1);
    en = 1'b0;
    step(2);
    busy = 1'b1;
    step(2);
    en = 1'b1;
    step(3);
    en = 1'b0;
    step(2);
    busy = 1'b0;
    s0 = n_start;
    step(100);
    chk(n_start == s0, "R4", n_start - s0, 0);
    // R3: fresh edge starts in the same cycle
    en = 1'b1;
    e = cyc;
    wait_start(a);
    chk(a == e, "R3", a, e);
    // R6: zero code, slow and fast
    for (int f = 0; f < 2; f++) begin
      step(1);
      en = 1'b0;
      code = 8'd0;
      fast = f[0];
      step(3);
      en = 1'b1;
      wait_start(a);
      wait_start(b);
      chk(b - a == period(0, f[0]), "R6", b - a, period(0, f[0]));
    end
    // R7: done pulse triggers immediate restart in zero-code mode
    step(1);
    en = 1'b0;
    fast = 1'b0;
    step(3);
    en = 1'b1;
    wait_start(a);
    step(10);
    done = 1'b1;
    e = cyc;
    wait_start(b);
    chk(b == e, "R7", b, e);
    step(1);
    done = 1'b0;
    // random mix: edge response and spacing
    for (int i = 0; i < 10; i++) begin
      int rc;
      bit rf;
      rc = int'($urandom_range(0, 3));
      rf = 1'($urandom_range(0, 1));
      step(1);
      en = 1'b0;
      code = 8'(rc);
      fast = rf;
      step(2 + int'($urandom_range(0, 20)));
      en = 1'b1;
      e = cyc;
      wait_start(a);
      chk(a == e, "R3", a, e);
      wait_start(b);
      chk(b - a == period(rc, rf), (rc == 0) ? "R6" : "R5", b - a, period(rc, rf));
    end
    step(1);
    en = 1'b0;
    step(5);
    finish_run();
  end
endmodule